// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, through a pair of capture registers, one per direction. The A-to-B register samples the A bus on the rising edge of its own clock and the B-to-A register samples the B bus on the rising edge of a second, independent clock. A per-direction select decides whether a driven port repeats the opposite bus live or replays the stored word. With these controls the block can pass data straight through, send a word captured earlier, or capture both buses while neither port is driven.

Two controls set the bus state. An active-low output enable isolates both ports when it is high. A direction control picks which single port is driven when the enable is low. Each tri-state port is modelled as three vectors: an input, an output and a per-bit output enable. The output enables and output data are combinational. Only the two registers hold state, and an asynchronous active-low reset clears them.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On every rising edge of `clkAb` the A-to-B register loads the value present on the A bus, whatever the state of `outEnN`, `dirAtoB` and both selects.
- R2: On every rising edge of `clkBa` the B-to-A register loads the value present on the B bus, whatever the state of `outEnN`, `dirAtoB` and both selects.
- R3: While `outEnN` is 1, `aOe` and `bOe` are all zeros. Both registers still capture on their clocks, and they hold their contents when not clocked.
- R4: While `outEnN` is 0 and `dirAtoB` is 0, `aOe` is all ones and `bOe` is all zeros. `aOut` equals `bIn` when `selStoredToA` is 0 and the B-to-A register when `selStoredToA` is 1.
- R5: While `outEnN` is 0 and `dirAtoB` is 1, `bOe` is all ones and `aOe` is all zeros. `bOut` equals `aIn` when `selStoredToB` is 0 and the A-to-B register when `selStoredToB` is 1.
- R6: `aOe` and `bOe` are never non-zero at the same time.
- R7: The value on a bus is the block's own output on a port it drives and the port input otherwise. A register whose source port is being driven captures the driven value.
- R8: `rstN` low clears both registers to zero at once and has no effect on `aOe` or `bOe`.
- R9: `aOut` is all zeros whenever port A is not driven, and `bOut` is all zeros whenever port B is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkAb | input | 1 | Capture clock of the A-to-B register |
| clkBa | input | 1 | Capture clock of the B-to-A register |
| rstN | input | 1 | Asynchronous active-low clear of both registers |
| outEnN | input | 1 | Active-low enable of port driving; 1 isolates both ports |
| dirAtoB | input | 1 | 1: drive port B; 0: drive port A |
| selStoredToA | input | 1 | 1: port A shows the B-to-A register; 0: live B bus |
| selStoredToB | input | 1 | 1: port B shows the A-to-B register; 0: live A bus |
| aIn | input | WIDTH | Value seen on the A pins |
| aOut | output | WIDTH | Data driven onto the A pins |
| aOe | output | WIDTH | Per-bit drive enable of the A pins |
| bIn | input | WIDTH | Value seen on the B pins |
| bOut | output | WIDTH | Data driven onto the B pins |
| bOe | output | WIDTH | Per-bit drive enable of the B pins |

## Verification
A wrong register value stays hidden until a driven port selects stored data. The bench therefore follows every capture with a replay through the stored path, so a bad word appears on `aOut` or `bOut` in the same step the select is applied. Wrong enable or direction decoding shows on `aOe` and `bOe` combinationally, with no clock in between. A self-driven capture that takes the pin input instead of the driven value only shows up after a later replay, so those cases use different values on the two pins.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic useRegA;
    logic useRegB;
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic       outEnN,
  input  logic       dirAtoB,
  input  logic       selStoredToA,
  input  logic       selStoredToB,
  output xcvr_ctrl_t ctl
);
  always_comb begin
    ctl.driveA  = !outEnN && !dirAtoB;
    ctl.driveB  = !outEnN && dirAtoB;
    ctl.useRegA = selStoredToA;
    ctl.useRegB = selStoredToB;
  end

  // R6: one driver at most
  always_comb begin
    a_r6_single_driver: assert (!(ctl.driveA && ctl.driveB));
  end
endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= d;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             rstN,
  input  xcvr_ctrl_t       ctl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);
  logic [WIDTH-1:0] regAb, regBa;
  logic [WIDTH-1:0] aDrv, bDrv, aBus, bBus;

  // driven data: the opposite port is always an input when this one drives
  always_comb begin
    aDrv = ctl.useRegA ? regBa : bIn;
    bDrv = ctl.useRegB ? regAb : aIn;
    aBus = ctl.driveA ? aDrv : aIn;
    bBus = ctl.driveB ? bDrv : bIn;
    aOut = ctl.driveA ? aDrv : '0;
    bOut = ctl.driveB ? bDrv : '0;
    aOe  = {WIDTH{ctl.driveA}};
    bOe  = {WIDTH{ctl.driveB}};
  end

  xcvr_capture_reg #(.WIDTH(WIDTH)) uRegAb (
    .clk(clkAb), .rstN(rstN), .d(aBus), .q(regAb)
  );
  xcvr_capture_reg #(.WIDTH(WIDTH)) uRegBa (
    .clk(clkBa), .rstN(rstN), .d(bBus), .q(regBa)
  );

  // R1: A-to-B register follows the A bus of the previous edge
  a_r1_capture_a: assert property (@(posedge clkAb) disable iff (!rstN)
    rstN |=> (regAb == $past(aBus)));
  // R2: B-to-A register follows the B bus of the previous edge
  a_r2_capture_b: assert property (@(posedge clkBa) disable iff (!rstN)
    rstN |=> (regBa == $past(bBus)));
  // R9: undriven port carries zero data
  always_comb begin
    a_r9_idle_zero: assert (((aOe != '0) || (aOut == '0)) && ((bOe != '0) || (bOut == '0)));
    a_r6_port_enables: assert (!((aOe != '0) && (bOe != '0)));
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             rstN,
  input  logic             outEnN,
  input  logic             dirAtoB,
  input  logic             selStoredToA,
  input  logic             selStoredToB,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);
  xcvr_ctrl_t ctl;

  xcvr_ctrl uCtrl (
    .outEnN(outEnN), .dirAtoB(dirAtoB),
    .selStoredToA(selStoredToA), .selStoredToB(selStoredToB), .ctl(ctl)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) uData (
    .clkAb(clkAb), .clkBa(clkBa), .rstN(rstN), .ctl(ctl),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );
endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int W = 8;
  logic clk = 0;
  logic clkAb = 0, clkBa = 0, rstN = 0;
  logic outEnN = 1, dirAtoB = 0, selStoredToA = 0, selStoredToB = 0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;
  logic [W-1:0] refAb = '0, refBa = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) dut (
    .clkAb(clkAb), .clkBa(clkBa), .rstN(rstN), .outEnN(outEnN), .dirAtoB(dirAtoB),
    .selStoredToA(selStoredToA), .selStoredToB(selStoredToB),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  function automatic logic drvA(); return !outEnN && !dirAtoB; endfunction
  function automatic logic drvB(); return !outEnN && dirAtoB; endfunction
  function automatic logic [W-1:0] expAOut();
    return drvA() ? (selStoredToA ? refBa : bIn) : '0;
  endfunction
  function automatic logic [W-1:0] expBOut();
    return drvB() ? (selStoredToB ? refAb : aIn) : '0;
  endfunction

  task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    #1;
    cmp(req, "aOe", aOe, {W{drvA()}});
    cmp(req, "bOe", bOe, {W{drvB()}});
    cmp(req, "aOut", aOut, expAOut());
    cmp(req, "bOut", bOut, expBOut());
    checks++;
    if ((aOe != '0) && (bOe != '0)) begin
      errors++;
      $display("FAIL R6 both enabled actual=%h/%h expected=one zero", aOe, bOe);
    end
  endtask

  task automatic setCtl(logic oe, logic dir, logic sa, logic sb);
    outEnN = oe; dirAtoB = dir; selStoredToA = sa; selStoredToB = sb;
  endtask

  // model bus value: driven value on a driven port (R7), else the pin input
  task automatic pulseAb();
    @(negedge clk);
    refAb = drvA() ? expAOut() : aIn;
    clkAb = 1; #2; clkAb = 0;
  endtask
  task automatic pulseBa();
    @(negedge clk);
    refBa = drvB() ? expBOut() : bIn;
    clkBa = 1; #2; clkBa = 0;
  endtask

  task automatic t_reset();
    rstN = 0; refAb = '0; refBa = '0;
    setCtl(0, 0, 1, 1); aIn = 8'h5A; bIn = 8'hA5;
    checkAll("R8");               // enables active during reset, A shows zero register
    setCtl(0, 1, 1, 1);
    checkAll("R8");
    #3 rstN = 1;
  endtask

  task automatic t_passAtoB();
    setCtl(0, 1, 0, 0);
    aIn = 8'h3C; checkAll("R5");
    aIn = 8'hC3; checkAll("R5");
  endtask

  task automatic t_passBtoA();
    setCtl(0, 0, 0, 0);
    bIn = 8'h81; checkAll("R4");
    bIn = 8'h7E; checkAll("R4");
  endtask

  task automatic t_storeReplay();
    setCtl(0, 1, 0, 0); aIn = 8'h12; bIn = 8'h34;
    pulseAb();                    // R1: B driven, A is input
    aIn = 8'hFF; setCtl(0, 1, 0, 1);
    checkAll("R1");               // bOut must be 12
    setCtl(0, 1, 0, 0); bIn = 8'h56;
    pulseBa();                    // R2 and R7: B is driven with aIn = FF
    setCtl(0, 0, 1, 0); bIn = 8'h00;
    checkAll("R7");               // aOut must be FF
  endtask

  task automatic t_isolation();
    setCtl(1, 0, 1, 1); aIn = 8'h9A; bIn = 8'hBC;
    checkAll("R3"); checkAll("R9");
    pulseAb(); pulseBa();         // R3: capture while isolated
    aIn = 8'h00; bIn = 8'h00; checkAll("R3");
    setCtl(0, 0, 1, 0); checkAll("R2");   // aOut = BC
    setCtl(0, 1, 0, 1); checkAll("R1");   // bOut = 9A
    setCtl(1, 1, 1, 1); checkAll("R9");
  endtask

  task automatic t_selfDriveA();
    setCtl(0, 0, 0, 0); bIn = 8'h44; aIn = 8'h11;
    pulseAb();                    // R7: A driven with bIn, A-to-B captures 44
    setCtl(0, 1, 0, 1); checkAll("R7");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      setCtl($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      aIn = W'($urandom); bIn = W'($urandom);
      if ($urandom_range(0, 1) == 1) pulseAb();
      if ($urandom_range(0, 1) == 1) pulseBa();
      checkAll("R6");
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #7;
    t_reset();
    t_passAtoB();
    t_passBtoA();
    t_storeReplay();
    t_isolation();
    t_selfDriveA();
    t_random();
    t_reset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule